// File: doc/BRIEF.md
# UART Bypass Pin Router

This block decides where the host-facing serial lines of the chip go. It has three routing states. While the synchronous reset is held, the block releases the transmit and request-to-send pads. Once reset is released, it connects the host serial pads to the on-chip UART. On an accepted bypass request, it hands the host serial link over to four general-purpose pins, so that another device on those pins can talk to the host directly.

A bypass request is only honoured while the link-idle input reports that no radio connections are open. Once bypass is taken, the block raises a deep-sleep request to the power controller. Bypass is sticky: only a new reset brings back the default routing. The switch-over uses a one-cycle park step. In that step the data multiplexers move while the bypass pins drive nothing. The pins that must drive are enabled one cycle later, so that no pad enable changes in the same cycle as its data source. General-purpose pins outside the bypass group always follow their normal direction and value registers.

Top module: `uart_bypass_router`

## Requirements
- R1: While `rst_n` is low, `pad_tx_oe` and `pad_rts_oe` are low in that same cycle.
- R2: From the first rising edge with `rst_n` high, both host pad enables are high and the routing is default: `pad_tx_o`=`core_tx`, `pad_rts_o`=`core_rts_n`, `core_rx`=`pad_rx_i`, `core_cts_n`=`pad_cts_i`.
- R3: A `byp_cmd` sampled high at a rising edge while `link_idle` is low has no effect: routing, pin enables and `sleep_req` remain as in default routing.
- R4: After a `byp_cmd` is accepted at edge k (with `link_idle` high, default routing), the following routing holds from edge k onward. The bypass pins are base+0 (transmit source), base+1 (request source), base+2 (clear-to-send output) and base+3 (receive output), with base = `BYP_BASE` = 4. `pad_tx_o`=`gp_i[4]`, `pad_rts_o`=`gp_i[5]`, `gp_o[6]`=`pad_cts_i` and `gp_o[7]`=`pad_rx_i`. `core_rx` and `core_cts_n` are held at 1.
- R5: In the cycle between edge k and edge k+1, `gp_oe[7:4]` are all 0 (park step). From edge k+1 onward, `gp_oe[6]` and `gp_oe[7]` are 1 and `gp_oe[4]` and `gp_oe[5]` are 0.
- R6: `sleep_req` is 0 until edge k+1. From edge k+1 it is 1, and it stays 1 until an edge with `rst_n` low.
- R7: While in bypass, further `byp_cmd` pulses have no effect. A reset followed by release restores R2 routing and clears `sleep_req`.
- R8: Pins outside the bypass group always give `gp_oe[i]`=`gp_dir[i]` and `gp_o[i]`=`gp_val[i]`. Bypass-group pins do the same until a command is accepted.
- R9: Both host pad enables stay high through the park step and in bypass, until reset.
- R10: `byp_cmd` sampled during reset, or at the first edge after release, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| byp_cmd | input | 1 | Bypass request strobe |
| link_idle | input | 1 | High when no radio connection is open |
| core_tx | input | 1 | Transmit data from the on-chip UART |
| core_rts_n | input | 1 | Request-to-send from the on-chip UART |
| core_rx | output | 1 | Receive data to the on-chip UART |
| core_cts_n | output | 1 | Clear-to-send to the on-chip UART |
| pad_tx_o | output | 1 | Host transmit pad data |
| pad_tx_oe | output | 1 | Host transmit pad enable |
| pad_rts_o | output | 1 | Host request pad data |
| pad_rts_oe | output | 1 | Host request pad enable |
| pad_rx_i | input | 1 | Host receive pad input |
| pad_cts_i | input | 1 | Host clear-to-send pad input |
| gp_dir | input | GP_W | Normal direction register (1 = drive) |
| gp_val | input | GP_W | Normal output value register |
| gp_i | input | GP_W | General-purpose pad inputs |
| gp_o | output | GP_W | General-purpose pad data |
| gp_oe | output | GP_W | General-purpose pad enables |
| sleep_req | output | 1 | Deep-sleep request to the power controller |

## Verification
The two functions that can fall in the same cycle are the bypass request and reset. This happens either when the strobe coincides with reset low, or when it arrives on the very first edge after release, while the router is still leaving its released state. The bench provokes both cases. It also pulses the strobe while `link_idle` is low, and repeatedly once bypass is already taken. A behavioural mode model in the bench predicts every pad, enable and sleep output each cycle, and the bench compares them, judging the park step and the enable order from the port values alone.

// File: rtl/ubr_pkg.sv
// Package: shared routing state and control word for the UART bypass router.
// Assumes a single clock domain for the whole router.
package ubr_pkg;

    // Routing state of the router.
    typedef enum logic [1:0] {
        RT_TRI  = 2'd0,   // pads released (reset)
        RT_HOST = 2'd1,   // host pads on the on-chip UART
        RT_PARK = 2'd2,   // muxes moved, bypass pins undriven
        RT_BYP  = 2'd3    // bypass fully active
    } route_t;

    // Registered control word decoded from the next state.
    typedef struct packed {
        logic host_oe;    // host pad drive permitted
        logic sel_byp;    // data muxes select the bypass path
        logic byp_oe;     // bypass output pins may drive
        logic sleep;      // deep-sleep request
    } route_ctl_t;

    // Control word for a given state.
    function automatic route_ctl_t ctl_of(route_t st);
        route_ctl_t c;
        c.host_oe = (st != RT_TRI);
        c.sel_byp = (st == RT_PARK) || (st == RT_BYP);
        c.byp_oe  = (st == RT_BYP);
        c.sleep   = (st == RT_BYP);
        return c;
    endfunction

endpackage

// File: rtl/ubr_mode_fsm.sv
// Module: routing-state sequencer. It holds the sticky routing state and
// registers the control word, so that every control output comes
// straight from a flop. Assumes byp_cmd is synchronous to clk. The only
// exit from bypass is the synchronous active-low reset.
module ubr_mode_fsm
    import ubr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byp_cmd,
    input  logic       link_idle,
    output route_ctl_t ctl
);

    route_t     state_q;
    route_t     state_d;
    route_ctl_t ctl_q;

    // Next-state rule: tri -> host, host -> park on an accepted request,
    // park -> bypass, bypass holds.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_TRI:  state_d = RT_HOST;
            RT_HOST: if (byp_cmd && link_idle) state_d = RT_PARK;
            RT_PARK: state_d = RT_BYP;
            RT_BYP:  state_d = RT_BYP;
            default: state_d = RT_TRI;
        endcase
    end

    // State and control registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RT_TRI;
            ctl_q   <= ctl_of(RT_TRI);
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_of(state_d);
        end
    end

    assign ctl = ctl_q;

endmodule

// File: rtl/ubr_host_mux.sv
// Module: host-side multiplexer. It picks the data for the host transmit
// and request pads, and what the on-chip UART receives. Assumes sel_byp
// and host_oe come from flops. The enables are also gated by rst_n, so
// that the pads are released in the very cycle reset is held.
module ubr_host_mux (
    input  logic rst_n,
    input  logic host_oe,
    input  logic sel_byp,
    input  logic core_tx,
    input  logic core_rts_n,
    input  logic pad_rx_i,
    input  logic pad_cts_i,
    input  logic alt_tx,
    input  logic alt_rts,
    output logic pad_tx_o,
    output logic pad_tx_oe,
    output logic pad_rts_o,
    output logic pad_rts_oe,
    output logic core_rx,
    output logic core_cts_n
);

    // Pad data source: on-chip UART or the bypass pins.
    always_comb begin
        pad_tx_o  = sel_byp ? alt_tx  : core_tx;
        pad_rts_o = sel_byp ? alt_rts : core_rts_n;
    end

    // Pad enables: released in reset, otherwise held on.
    always_comb begin
        pad_tx_oe  = host_oe & rst_n;
        pad_rts_oe = host_oe & rst_n;
    end

    // On-chip UART inputs are parked idle-high while bypassed.
    always_comb begin
        core_rx    = sel_byp ? 1'b1 : pad_rx_i;
        core_cts_n = sel_byp ? 1'b1 : pad_cts_i;
    end

endmodule

// File: rtl/ubr_gp_mux.sv
// Module: general-purpose pin multiplexer. Four consecutive pins from
// BYP_BASE take the bypass roles in the order transmit source, request
// source, clear-to-send out, receive out. All other pins pass the normal
// direction and value registers unchanged. Assumes BYP_BASE+4 <= GP_W.
module ubr_gp_mux #(
    parameter int GP_W     = 8,
    parameter int BYP_BASE = 4
) (
    input  logic            sel_byp,
    input  logic            byp_oe,
    input  logic [GP_W-1:0] gp_dir,
    input  logic [GP_W-1:0] gp_val,
    input  logic            pad_rx_i,
    input  logic            pad_cts_i,
    output logic [GP_W-1:0] gp_o,
    output logic [GP_W-1:0] gp_oe
);

    localparam int ROLE_CTS = 2;
    localparam int ROLE_RX  = 3;
    localparam int BYP_TOP  = BYP_BASE + 3;

    for (genvar i = 0; i < GP_W; i++) begin : g_pin
        if (i >= BYP_BASE && i <= BYP_TOP) begin : g_byp
            localparam int ROLE   = i - BYP_BASE;
            localparam bit IS_OUT = (ROLE == ROLE_CTS) || (ROLE == ROLE_RX);
            logic src;
            // Source for a driving bypass role.
            always_comb begin
                src = (ROLE == ROLE_CTS) ? pad_cts_i : pad_rx_i;
            end
            // Bypass pin: registers in default routing, role when bypassed.
            always_comb begin
                gp_o[i]  = sel_byp ? (IS_OUT ? src : 1'b0) : gp_val[i];
                gp_oe[i] = sel_byp ? (IS_OUT & byp_oe) : gp_dir[i];
            end
        end else begin : g_plain
            // Plain pin: normal registers only.
            always_comb begin
                gp_o[i]  = gp_val[i];
                gp_oe[i] = gp_dir[i];
            end
        end
    end

endmodule

// File: rtl/uart_bypass_router.sv
// Module: top of the UART bypass router. It ties the sequencer to the
// host-side and general-purpose multiplexers. Assumes a synchronous
// active-low reset and BYP_BASE+4 <= GP_W.
module uart_bypass_router #(
    parameter int GP_W     = 8,
    parameter int BYP_BASE = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            byp_cmd,
    input  logic            link_idle,
    input  logic            core_tx,
    input  logic            core_rts_n,
    output logic            core_rx,
    output logic            core_cts_n,
    output logic            pad_tx_o,
    output logic            pad_tx_oe,
    output logic            pad_rts_o,
    output logic            pad_rts_oe,
    input  logic            pad_rx_i,
    input  logic            pad_cts_i,
    input  logic [GP_W-1:0] gp_dir,
    input  logic [GP_W-1:0] gp_val,
    input  logic [GP_W-1:0] gp_i,
    output logic [GP_W-1:0] gp_o,
    output logic [GP_W-1:0] gp_oe,
    output logic            sleep_req
);
    import ubr_pkg::*;

    localparam int IDX_TX  = BYP_BASE;
    localparam int IDX_RTS = BYP_BASE + 1;

    route_ctl_t ctl;
    logic       gp_in_unused;

    // Only the two bypass source pins are read here.
    assign gp_in_unused = ^gp_i;

    ubr_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .byp_cmd   (byp_cmd),
        .link_idle (link_idle),
        .ctl       (ctl)
    );

    ubr_host_mux u_host (
        .rst_n      (rst_n),
        .host_oe    (ctl.host_oe),
        .sel_byp    (ctl.sel_byp),
        .core_tx    (core_tx),
        .core_rts_n (core_rts_n),
        .pad_rx_i   (pad_rx_i),
        .pad_cts_i  (pad_cts_i),
        .alt_tx     (gp_i[IDX_TX]),
        .alt_rts    (gp_i[IDX_RTS]),
        .pad_tx_o   (pad_tx_o),
        .pad_tx_oe  (pad_tx_oe),
        .pad_rts_o  (pad_rts_o),
        .pad_rts_oe (pad_rts_oe),
        .core_rx    (core_rx),
        .core_cts_n (core_cts_n)
    );

    ubr_gp_mux #(.GP_W(GP_W), .BYP_BASE(BYP_BASE)) u_gp (
        .sel_byp   (ctl.sel_byp),
        .byp_oe    (ctl.byp_oe),
        .gp_dir    (gp_dir),
        .gp_val    (gp_val),
        .pad_rx_i  (pad_rx_i),
        .pad_cts_i (pad_cts_i),
        .gp_o      (gp_o),
        .gp_oe     (gp_oe)
    );

    // Sleep request straight from its flop.
    assign sleep_req = ctl.sleep;

endmodule

// File: rtl/ubr_checker.sv
// Module: property checker for the UART bypass router, attached by bind.
// It sees only the top-level ports.
module ubr_checker #(
    parameter int GP_W     = 8,
    parameter int BYP_BASE = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            byp_cmd,
    input logic            link_idle,
    input logic            core_rx,
    input logic            core_cts_n,
    input logic            pad_tx_o,
    input logic            pad_tx_oe,
    input logic            pad_rts_o,
    input logic            pad_rts_oe,
    input logic            pad_rx_i,
    input logic            pad_cts_i,
    input logic [GP_W-1:0] gp_i,
    input logic [GP_W-1:0] gp_o,
    input logic [GP_W-1:0] gp_oe,
    input logic            sleep_req
);
    localparam int I_TX  = BYP_BASE;
    localparam int I_RTS = BYP_BASE + 1;
    localparam int I_CTS = BYP_BASE + 2;
    localparam int I_RX  = BYP_BASE + 3;

    // Released pads whenever reset is held.
    always_comb begin
        if (!rst_n) begin
            p_tri_in_reset_r1: assert (!pad_tx_oe && !pad_rts_oe);
        end
    end

    p_sleep_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> sleep_req);

    p_accept_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> ($past(link_idle, 2) && $past(byp_cmd, 2)));

    p_park_before_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep_req) |-> ($past(gp_oe[I_RX]) == 1'b0 && $past(gp_oe[I_CTS]) == 1'b0));

    p_byp_dirs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (gp_oe[I_RX] && gp_oe[I_CTS] && !gp_oe[I_TX] && !gp_oe[I_RTS]));

    p_byp_route_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (pad_tx_o == gp_i[I_TX] && pad_rts_o == gp_i[I_RTS]
                       && gp_o[I_RX] == pad_rx_i && gp_o[I_CTS] == pad_cts_i
                       && core_rx && core_cts_n));

    p_host_oe_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> (pad_tx_oe && pad_rts_oe));

endmodule

bind uart_bypass_router ubr_checker #(.GP_W(GP_W), .BYP_BASE(BYP_BASE)) u_ubr_chk (.*);

// File: tb/uart_bypass_router_tb_top.sv
// Bench: a behavioural mode model predicts every output each cycle.
module uart_bypass_router_tb_top;

    localparam int GP_W = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            byp_cmd = 1'b0;
    logic            link_idle = 1'b0;
    logic            core_tx = 1'b1;
    logic            core_rts_n = 1'b1;
    logic            pad_rx_i = 1'b1;
    logic            pad_cts_i = 1'b1;
    logic [GP_W-1:0] gp_dir = '0;
    logic [GP_W-1:0] gp_val = '0;
    logic [GP_W-1:0] gp_i = '0;
    logic            core_rx, core_cts_n, pad_tx_o, pad_tx_oe, pad_rts_o, pad_rts_oe;
    logic [GP_W-1:0] gp_o, gp_oe;
    logic            sleep_req;

    int    checks = 0;
    int    errors = 0;
    int    mode   = 0;     // 0 released, 1 host, 2 park, 3 bypass
    int    cyc    = 0;
    string ctx    = "";

    always #10 clk = ~clk;

    uart_bypass_router #(.GP_W(GP_W), .BYP_BASE(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .byp_cmd(byp_cmd), .link_idle(link_idle),
        .core_tx(core_tx), .core_rts_n(core_rts_n), .core_rx(core_rx),
        .core_cts_n(core_cts_n), .pad_tx_o(pad_tx_o), .pad_tx_oe(pad_tx_oe),
        .pad_rts_o(pad_rts_o), .pad_rts_oe(pad_rts_oe), .pad_rx_i(pad_rx_i),
        .pad_cts_i(pad_cts_i), .gp_dir(gp_dir), .gp_val(gp_val), .gp_i(gp_i),
        .gp_o(gp_o), .gp_oe(gp_oe), .sleep_req(sleep_req)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s%s %s: actual %0d expected %0d (t=%0t)", req, ctx, what, act, exp, $time);
        end
    endtask

    // Compare every output against the model for the current mode and inputs.
    task automatic compare();
        bit sel = (mode >= 2);
        bit hoe = rst_n && (mode != 0);
        string hreq = !rst_n ? "R1" : ((mode >= 2) ? "R9" : "R2");
        string dreq = sel ? "R4" : "R2";
        chk(pad_tx_oe == hoe, hreq, "pad_tx_oe", pad_tx_oe, hoe);
        chk(pad_rts_oe == hoe, hreq, "pad_rts_oe", pad_rts_oe, hoe);
        if (hoe) begin
            chk(pad_tx_o == (sel ? gp_i[4] : core_tx), dreq, "pad_tx_o", pad_tx_o, sel ? gp_i[4] : core_tx);
            chk(pad_rts_o == (sel ? gp_i[5] : core_rts_n), dreq, "pad_rts_o", pad_rts_o, sel ? gp_i[5] : core_rts_n);
        end
        chk(core_rx == (sel ? 1'b1 : pad_rx_i), dreq, "core_rx", core_rx, sel ? 1 : pad_rx_i);
        chk(core_cts_n == (sel ? 1'b1 : pad_cts_i), dreq, "core_cts_n", core_cts_n, sel ? 1 : pad_cts_i);
        for (int i = 0; i < GP_W; i++) begin
            bit eoe, eo;
            bit inb = (i >= 4 && i <= 7);
            if (inb && sel) begin
                eoe = (mode == 3) && (i == 6 || i == 7);
                eo  = (i == 6) ? pad_cts_i : pad_rx_i;
            end else begin
                eoe = gp_dir[i];
                eo  = gp_val[i];
            end
            chk(gp_oe[i] == eoe, (inb && sel) ? "R5" : "R8", $sformatf("gp_oe[%0d]", i), gp_oe[i], eoe);
            if (eoe)
                chk(gp_o[i] == eo, (inb && sel) ? "R4" : "R8", $sformatf("gp_o[%0d]", i), gp_o[i], eo);
        end
        chk(sleep_req == (mode == 3), "R6", "sleep_req", sleep_req, mode == 3);
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input bit r, input bit cmd, input bit idle);
        @(negedge clk);
        rst_n = r; byp_cmd = cmd; link_idle = idle;
        core_tx = 1'($urandom); core_rts_n = 1'($urandom);
        pad_rx_i = 1'($urandom); pad_cts_i = 1'($urandom);
        gp_dir = GP_W'($urandom); gp_val = GP_W'($urandom); gp_i = GP_W'($urandom);
        #2;
        compare();
        @(posedge clk);
        if (!r)                 mode = 0;
        else if (mode == 0)     mode = 1;
        else if (mode == 1)     mode = (cmd && idle) ? 2 : 1;
        else                    mode = 3;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_run();
        end
    end

    initial begin
        // R1 and R10: reset with requests present.
        ctx = "/R10";
        for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b1, 1'b1);            // first edge after release ignored
        ctx = "";
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 1'b1);
        // R3: request while links are open.
        ctx = "/R3";
        for (int k = 0; k < 6; k++) step(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0);
        // R4, R5, R6: accepted request, park step, then bypass.
        ctx = "";
        step(1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 1'b0);
        // R7: more requests in bypass change nothing.
        ctx = "/R7";
        for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'(k % 2));
        // R7: reset restores default routing.
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b1);
        // Back-to-back: accept, then reset during the park step.
        ctx = "/R10";
        step(1'b1, 1'b1, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b1);
        ctx = "";
        for (int k = 0; k < 60; k++) step(1'b1, 1'($urandom), 1'($urandom));
        @(negedge clk);
        finish_run();
    end

endmodule